// File: doc/BRIEF.md
# Run/Sleep Peripheral Clock Enable Gater

This block produces per-peripheral clock enables for two bus domains: a set of high-speed bus (AHB) clients and a set of peripheral bus (APB) clients. Each client has two mask bits. The run bit decides whether its clock runs while the core is active. The sleep bit can additionally stop that clock, without software action, once the core has gone to sleep. Software loads the four masks through a single-cycle write port. Each write selects one mask, and the low bits of the data word are stored in it.

The core raises a one-cycle sleep request after it executes a wait-for-interrupt or wait-for-event instruction. The block then tracks a sleep state until a wakeup event returns it to run operation. In run operation each enable follows its run bit. In sleep each enable is the AND of the run bit and the sleep bit. Software can therefore stop a clock during sleep in two ways: by clearing the run bit before sleeping, or by leaving the sleep bit cleared.

The enables are registered on the falling clock edge. A clock gate downstream therefore only ever sees an enable that changed while the clock was low, so no shortened pulse can reach a peripheral.

Top module: `run_sleep_clk_gater`

## Requirements
- R1: While `rst` is high at a rising edge, the sleep state clears and all run masks clear. All sleep masks are set to all ones. The enables become zero at the following falling edge.
- R2: A write (`wr_en`=1 at a rising edge) stores `wr_data` bits [N-1:0] of the addressed domain's width into one mask. `wr_sel` encodes the target: 0 = AHB run, 1 = AHB sleep, 2 = APB run, 3 = APB sleep. Higher data bits are ignored.
- R3: When `sleep_active` is 0, each enable equals its run mask bit.
- R4: A rising edge with `sleep_req`=1 and `wakeup`=0 sets `sleep_active` to 1. With both low, `sleep_active` keeps its value.
- R5: When `sleep_active` is 1, each enable equals its run bit AND its sleep bit.
- R6: A rising edge with `wakeup`=1 clears `sleep_active`, even when `sleep_req` is also 1. The enables then return to the run masks.
- R7: Enable outputs change only at falling clock edges. A state change made at a rising edge shows on the enables half a cycle later, and not before.
- R8: A mask written while asleep takes effect at the next falling edge, with no wakeup needed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Source clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Mask write strobe |
| wr_sel | input | 2 | Mask select (0 AHB run, 1 AHB sleep, 2 APB run, 3 APB sleep) |
| wr_data | input | DATA_W | Mask write data |
| sleep_req | input | 1 | Core entered wait-for-interrupt/event |
| wakeup | input | 1 | Wakeup event |
| sleep_active | output | 1 | Block is in sleep state |
| ahb_clk_en | output | N_AHB | Per-client AHB clock enables |
| apb_clk_en | output | N_APB | Per-client APB clock enables |

## Verification
The enables are first tried with the masks at their reset values, both awake and asleep. This shows that the all-ones sleep defaults leave running clocks alone. Masks with differing run and sleep patterns are then entered into sleep, which separates the AND in sleep from plain run selection. Mask writes made during sleep, and coincident sleep and wake requests, cover the remaining paths. A long stretch of random writes, requests and wakeups is compared every cycle against a behavioural model, both just after the rising edge and after the falling edge, which exposes any enable that moves on the wrong edge.

// File: rtl/cg_pkg.sv
package cg_pkg;

    localparam int unsigned MAX_W = 32;

    typedef enum logic [1:0] {
        SEL_AHB_RUN = 2'd0,
        SEL_AHB_SLP = 2'd1,
        SEL_APB_RUN = 2'd2,
        SEL_APB_SLP = 2'd3
    } mask_sel_e;

    typedef struct packed {
        logic [MAX_W-1:0] run;
        logic [MAX_W-1:0] slp;
    } mask_pair_t;

    // Effective enable for one domain given its mask pair and mode
    function automatic logic [MAX_W-1:0] effective_en(input mask_pair_t m, input logic asleep);
        logic [MAX_W-1:0] r;
        r = asleep ? (m.run & m.slp) : m.run;
        return r;
    endfunction

endpackage

// File: rtl/cg_mask_regs.sv
module cg_mask_regs
    import cg_pkg::*;
#(
    parameter int unsigned W       = 8,
    parameter int unsigned DATA_W  = 16,
    parameter logic [1:0]  RUN_SEL = 2'd0,
    parameter logic [1:0]  SLP_SEL = 2'd1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [1:0]        wr_sel,
    input  logic [DATA_W-1:0] wr_data,
    output logic [W-1:0]      run_mask,
    output logic [W-1:0]      slp_mask
);

    localparam logic [W-1:0] SLP_DEFAULT = {W{1'b1}};

    logic hit_run;
    logic hit_slp;

    assign hit_run = wr_en && (wr_sel == RUN_SEL);
    assign hit_slp = wr_en && (wr_sel == SLP_SEL);

    always_ff @(posedge clk) begin
        if (rst) begin
            run_mask <= '0;
            slp_mask <= SLP_DEFAULT;
        end else begin
            if (hit_run) run_mask <= wr_data[W-1:0];
            if (hit_slp) slp_mask <= wr_data[W-1:0];
        end
    end

endmodule

// File: rtl/cg_mode_track.sv
module cg_mode_track (
    input  logic clk,
    input  logic rst,
    input  logic sleep_req,
    input  logic wakeup,
    output logic sleep_active
);

    always_ff @(posedge clk) begin
        if (rst)            sleep_active <= 1'b0;
        else if (wakeup)    sleep_active <= 1'b0;
        else if (sleep_req) sleep_active <= 1'b1;
    end

endmodule

// File: rtl/cg_enable_stage.sv
module cg_enable_stage
    import cg_pkg::*;
#(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         asleep,
    input  logic [W-1:0] run_mask,
    input  logic [W-1:0] slp_mask,
    output logic [W-1:0] clk_en
);

    mask_pair_t       pair;
    logic [MAX_W-1:0] full_en;

    always_comb begin
        pair     = '0;
        pair.run = MAX_W'(run_mask);
        pair.slp = MAX_W'(slp_mask);
        full_en  = effective_en(pair, asleep);
    end

    // Falling-edge update keeps each enable steady while the clock is high
    always_ff @(negedge clk) begin
        if (rst) clk_en <= '0;
        else     clk_en <= full_en[W-1:0];
    end

endmodule

// File: rtl/run_sleep_clk_gater.sv
module run_sleep_clk_gater
    import cg_pkg::*;
#(
    parameter int unsigned N_AHB  = 8,
    parameter int unsigned N_APB  = 12,
    parameter int unsigned DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [1:0]        wr_sel,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              sleep_req,
    input  logic              wakeup,
    output logic              sleep_active,
    output logic [N_AHB-1:0]  ahb_clk_en,
    output logic [N_APB-1:0]  apb_clk_en
);

    localparam int unsigned N_DOM = 2;

    logic [N_AHB-1:0] ahb_run;
    logic [N_AHB-1:0] ahb_slp;
    logic [N_APB-1:0] apb_run;
    logic [N_APB-1:0] apb_slp;

    cg_mode_track u_mode (
        .clk          (clk),
        .rst          (rst),
        .sleep_req    (sleep_req),
        .wakeup       (wakeup),
        .sleep_active (sleep_active)
    );

    for (genvar d = 0; d < N_DOM; d++) begin : g_dom
        if (d == 0) begin : g_ahb
            cg_mask_regs #(
                .W(N_AHB), .DATA_W(DATA_W),
                .RUN_SEL(SEL_AHB_RUN), .SLP_SEL(SEL_AHB_SLP)
            ) u_regs (
                .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel),
                .wr_data(wr_data), .run_mask(ahb_run), .slp_mask(ahb_slp)
            );
            cg_enable_stage #(.W(N_AHB)) u_en (
                .clk(clk), .rst(rst), .asleep(sleep_active),
                .run_mask(ahb_run), .slp_mask(ahb_slp), .clk_en(ahb_clk_en)
            );
        end else begin : g_apb
            cg_mask_regs #(
                .W(N_APB), .DATA_W(DATA_W),
                .RUN_SEL(SEL_APB_RUN), .SLP_SEL(SEL_APB_SLP)
            ) u_regs (
                .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel),
                .wr_data(wr_data), .run_mask(apb_run), .slp_mask(apb_slp)
            );
            cg_enable_stage #(.W(N_APB)) u_en (
                .clk(clk), .rst(rst), .asleep(sleep_active),
                .run_mask(apb_run), .slp_mask(apb_slp), .clk_en(apb_clk_en)
            );
        end
    end

endmodule

// File: rtl/cg_checker.sv
module cg_checker #(
    parameter int unsigned N_AHB  = 8,
    parameter int unsigned N_APB  = 12,
    parameter int unsigned DATA_W = 16
) (
    input logic              clk,
    input logic              rst,
    input logic              wr_en,
    input logic [1:0]        wr_sel,
    input logic [DATA_W-1:0] wr_data,
    input logic              sleep_req,
    input logic              wakeup,
    input logic              sleep_active,
    input logic [N_AHB-1:0]  ahb_run,
    input logic [N_AHB-1:0]  ahb_slp,
    input logic [N_APB-1:0]  apb_run,
    input logic [N_APB-1:0]  apb_slp,
    input logic [N_AHB-1:0]  ahb_clk_en,
    input logic [N_APB-1:0]  apb_clk_en
);

    a_r1_reset_awake: assert property (@(posedge clk)
        rst |=> !sleep_active);

    a_r2_ahb_run_write: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_sel == 2'd0) |=> ahb_run == $past(wr_data[N_AHB-1:0]));

    a_r2_apb_slp_write: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_sel == 2'd3) |=> apb_slp == $past(wr_data[N_APB-1:0]));

    a_r3_run_follow: assert property (@(posedge clk) disable iff (rst)
        !sleep_active |-> (ahb_clk_en == ahb_run && apb_clk_en == apb_run));

    a_r4_enter_sleep: assert property (@(posedge clk) disable iff (rst)
        (sleep_req && !wakeup) |=> sleep_active);

    a_r4_hold_mode: assert property (@(posedge clk) disable iff (rst)
        (!sleep_req && !wakeup) |=> $stable(sleep_active));

    a_r5_sleep_gate: assert property (@(posedge clk) disable iff (rst)
        sleep_active |-> (ahb_clk_en == (ahb_run & ahb_slp) &&
                          apb_clk_en == (apb_run & apb_slp)));

    a_r6_wake_wins: assert property (@(posedge clk) disable iff (rst)
        wakeup |=> !sleep_active);

endmodule

bind run_sleep_clk_gater cg_checker #(
    .N_AHB(N_AHB), .N_APB(N_APB), .DATA_W(DATA_W)
) u_cg_checker (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .sleep_req(sleep_req), .wakeup(wakeup), .sleep_active(sleep_active),
    .ahb_run(ahb_run), .ahb_slp(ahb_slp), .apb_run(apb_run), .apb_slp(apb_slp),
    .ahb_clk_en(ahb_clk_en), .apb_clk_en(apb_clk_en)
);

// File: tb/run_sleep_clk_gater_bench.sv
module run_sleep_clk_gater_bench;

    localparam int unsigned N_AHB  = 8;
    localparam int unsigned N_APB  = 12;
    localparam int unsigned DATA_W = 16;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              wr_en = 1'b0;
    logic [1:0]        wr_sel = 2'd0;
    logic [DATA_W-1:0] wr_data = '0;
    logic              sleep_req = 1'b0;
    logic              wakeup = 1'b0;
    logic              sleep_active;
    logic [N_AHB-1:0]  ahb_clk_en;
    logic [N_APB-1:0]  apb_clk_en;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // behavioural reference state
    bit        m_sleep = 0;
    bit [31:0] m_ahb_run = 0, m_ahb_slp = 32'hFFFF_FFFF;
    bit [31:0] m_apb_run = 0, m_apb_slp = 32'hFFFF_FFFF;
    bit [31:0] exp_ahb = 0, exp_apb = 0;

    always #10 clk = ~clk;   // 50 MHz

    run_sleep_clk_gater #(.N_AHB(N_AHB), .N_APB(N_APB), .DATA_W(DATA_W)) u_run_sleep_clk_gater (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .sleep_req(sleep_req), .wakeup(wakeup), .sleep_active(sleep_active),
        .ahb_clk_en(ahb_clk_en), .apb_clk_en(apb_clk_en)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] expv);
        checks++;
        if (act !== expv) begin
            errors++;
            $display("FAIL %s: actual %h expected %h at %0t", tag, act, expv, $time);
        end
    endtask

    // One clock: drive inputs, advance model at the rising edge, check just
    // after it (R7: old value kept) and after the falling edge (new value).
    task automatic step(input bit r, input bit we, input bit [1:0] sel,
                        input bit [DATA_W-1:0] d, input bit sq, input bit wk);
        bit [31:0] mask_a, mask_p;
        rst = r; wr_en = we; wr_sel = sel; wr_data = d; sleep_req = sq; wakeup = wk;
        @(posedge clk);
        if (r) begin
            m_sleep = 0; m_ahb_run = 0; m_apb_run = 0;
            m_ahb_slp = 32'hFFFF_FFFF; m_apb_slp = 32'hFFFF_FFFF;
        end else begin
            if (we) begin
                case (sel)
                    2'd0: m_ahb_run = 32'(d);
                    2'd1: m_ahb_slp = 32'(d);
                    2'd2: m_apb_run = 32'(d);
                    default: m_apb_slp = 32'(d);
                endcase
            end
            if (wk) m_sleep = 0;
            else if (sq) m_sleep = 1;
        end
        #1;
        check("R7 ahb early", 32'(ahb_clk_en), exp_ahb);
        check("R7 apb early", 32'(apb_clk_en), exp_apb);
        mask_a = (1 << N_AHB) - 1;
        mask_p = (1 << N_APB) - 1;
        if (r) begin
            exp_ahb = 0; exp_apb = 0;
        end else if (m_sleep) begin
            exp_ahb = m_ahb_run & m_ahb_slp & mask_a;
            exp_apb = m_apb_run & m_apb_slp & mask_p;
        end else begin
            exp_ahb = m_ahb_run & mask_a;
            exp_apb = m_apb_run & mask_p;
        end
        check(r ? "R1 mode" : (wk ? "R6 mode" : "R4 mode"), 32'(sleep_active), 32'(m_sleep));
        @(negedge clk); #2;
        check(r ? "R1 ahb" : (m_sleep ? "R5 ahb" : "R3 ahb"), 32'(ahb_clk_en), exp_ahb);
        check(r ? "R1 apb" : (m_sleep ? "R5 apb" : "R3 apb"), 32'(apb_clk_en), exp_apb);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step(0, 0, 0, 0, 0, 0);
    endtask

    initial begin
        @(negedge clk); @(negedge clk); #2;
        // R1: reset state
        step(1, 0, 0, 0, 0, 0);
        step(1, 0, 0, 0, 0, 0);
        idle(1);
        // R1: sleep with defaults keeps everything off
        step(0, 0, 0, 0, 1, 0); idle(1);
        step(0, 0, 0, 0, 0, 1);
        // R2 R3: run masks
        step(0, 1, 2'd0, 16'hFFA5, 0, 0);
        step(0, 1, 2'd2, 16'hFF0F, 0, 0);
        // R1: all-ones sleep default leaves clocks running in sleep
        step(0, 0, 0, 0, 1, 0); idle(2);
        step(0, 0, 0, 0, 0, 1);
        // R5: differing sleep masks
        step(0, 1, 2'd1, 16'h000F, 0, 0);
        step(0, 1, 2'd3, 16'h03C0, 0, 0);
        step(0, 0, 0, 0, 1, 0); idle(1);
        // R8: writes while asleep act at once
        step(0, 1, 2'd0, 16'h00FF, 0, 0);
        step(0, 1, 2'd3, 16'h0FFF, 0, 0);
        // R6: wakeup restores run masks; simultaneous request loses to wakeup
        step(0, 0, 0, 0, 0, 1);
        step(0, 0, 0, 0, 1, 1);
        idle(1);
        step(0, 0, 0, 0, 1, 0);
        step(0, 0, 0, 0, 1, 1);
        // R1: reset mid-run returns masks to defaults
        step(1, 0, 0, 0, 0, 0);
        step(0, 0, 0, 0, 1, 0);
        step(0, 0, 0, 0, 0, 1);
        // random stretch
        for (int i = 0; i < 3000; i++) begin
            step(($urandom % 200) == 0, ($urandom % 3) == 0, 2'($urandom),
                 16'($urandom), ($urandom % 6) == 0, ($urandom % 8) == 0);
        end
        done = 1;
    end

    initial begin
        for (int c = 0; c < 100000 && !done; c++) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual hung expected done");
        end
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule